// File: doc/BRIEF.md
# Hypervisor Host-Mode Control Decoder

This block turns the host-mode virtualization controls of a processor core into three sets of decisions. The inputs are the current exception level, a host-mode enable and a host-context bit, a per-class routing bit and a per-class monitor routing bit for each physical interrupt class, and an access tag on a decoded system-register access. From these it picks the exception level that takes each interrupt class, the physical register bank that the access reaches, and the translation regime in use.

The decoder has no clock and holds no state. Every output depends only on the inputs present at that moment. A core can therefore place it next to its control registers and re-evaluate it after any change to the exception level or to the controls. The storage of the registers, the table walk and the pipeline hookup all live outside this block.

Top module: `hyp_host_ctrl_dec`

## Requirements
- R1: If a class's monitor routing bit is 1, that class's target is level 3 (code 3). This rule overrides every other routing rule.
- R2: At level 0 with host_ctx=1, a class whose monitor bit is 0 targets level 2, whatever its route_hyp bit says.
- R3: In all other cases a class targets level 2 if its route_hyp bit is 1 and level 1 if it is 0. The class order is bit 0 IRQ, bit 1 FIQ, bit 2 SError.
- R4: A target is never below cur_el. When the rules above give a lower level, the target is cur_el.
- R5: Access tags are 0 for an EL1-named register, 1 for an EL2-named register, 2 for the level-0/2 alias, and 3 for reserved. For bank, 0 means the EL1 bank and 1 means the EL2 bank. A tag-0 access reaches the EL2 bank when cur_el=2 and host_mode=1, and the EL1 bank otherwise, with acc_undef=0.
- R6: A tag-2 access at cur_el=2 with host_mode=1 reaches the EL1 bank with acc_undef=0.
- R7: A tag-2 access in any other state, and any tag-3 access, gives acc_undef=1 and acc_bank=0.
- R8: A tag-1 access always reaches the EL2 bank with acc_undef=0.
- R9: The regime codes are 1 for the level-1/0 space, 2 for the level-2 space and 3 for the level-3 space. At level 0 the regime is 2 when host_mode=1 and host_ctx=1, and 1 otherwise. At levels 1, 2 and 3 the regime code equals cur_el.
- R10: Regime 1 has two regions and ASIDs. Regime 2 has two regions and ASIDs only when host_mode=1, and otherwise a single region with no ASID. Regime 3 has a single region and no ASID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_el | input | 2 | Current exception level, 0 to 3 |
| host_mode | input | 1 | Host-extension mode enable |
| host_ctx | input | 1 | Level 0 belongs to the host (1) or a guest (0) |
| route_hyp | input | NUM_CLASSES | Per-class routing to level 2 (1) or level 1 (0) |
| route_mon | input | NUM_CLASSES | Per-class routing to level 3 by the secure monitor |
| acc_tag | input | 2 | Alias class of the decoded system-register access |
| irq_target | output | NUM_CLASSES x 2 | Target exception level for each interrupt class |
| acc_bank | output | 1 | Physical bank reached: 0 EL1, 1 EL2 |
| acc_undef | output | 1 | The access is undefined in the current state |
| xlat_regime | output | 2 | Active translation regime code |
| xlat_two_regions | output | 1 | The regime has a lower and an upper region |
| xlat_asid | output | 1 | The regime supports address space identifiers |

## Verification
The assertions check only combinations in which every input holds a known 0 or 1. They are immediate checks, so they assume the inputs have settled, and they skip any evaluation in which an input is still X. The bench drives every input from time zero and changes all of them together, one step after a clock edge. It then sweeps every combination of level, controls, routing bits and tag, so the stimulus never reaches a state the checks rule out.

// File: rtl/hhc_pkg.sv
package hhc_pkg;

  localparam int EL_W = 2;

  localparam logic [EL_W-1:0] LVL0 = 2'd0;
  localparam logic [EL_W-1:0] LVL1 = 2'd1;
  localparam logic [EL_W-1:0] LVL2 = 2'd2;
  localparam logic [EL_W-1:0] LVL3 = 2'd3;

  typedef enum logic [1:0] {
    TAG_LOW_NAME  = 2'd0,
    TAG_HYP_NAME  = 2'd1,
    TAG_ALIAS_02  = 2'd2,
    TAG_RESERVED  = 2'd3
  } acc_tag_e;

  typedef enum logic [1:0] {
    RGM_NONE = 2'd0,
    RGM_K10  = 2'd1,
    RGM_HYP  = 2'd2,
    RGM_MON  = 2'd3
  } regime_e;

  typedef struct packed {
    regime_e id;
    logic    two_regions;
    logic    asid;
  } regime_t;

  localparam logic BANK_LOW = 1'b0;
  localparam logic BANK_HYP = 1'b1;

  function automatic logic [EL_W-1:0] lvl_raise(input logic [EL_W-1:0] want,
                                                input logic [EL_W-1:0] floor_lvl);
    return (want < floor_lvl) ? floor_lvl : want;
  endfunction

  function automatic regime_t regime_attrs(input regime_e id, input logic host_mode);
    regime_t r;
    r.id = id;
    unique case (id)
      RGM_K10: begin r.two_regions = 1'b1;      r.asid = 1'b1;      end
      RGM_HYP: begin r.two_regions = host_mode; r.asid = host_mode; end
      default: begin r.two_regions = 1'b0;      r.asid = 1'b0;      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/hhc_route_lane.sv
module hhc_route_lane
  import hhc_pkg::*;
(
  input  logic [EL_W-1:0] cur_el,
  input  logic            el0_trap,
  input  logic            hyp_bit,
  input  logic            mon_bit,
  output logic [EL_W-1:0] tgt,
  output logic            mon_hit,
  output logic            forced,
  output logic            clamped
);

  logic [EL_W-1:0] raw_tgt;

  always_comb begin
    mon_hit = mon_bit;
    forced  = !mon_bit && el0_trap;
    if (mon_bit)       raw_tgt = LVL3;
    else if (el0_trap) raw_tgt = LVL2;
    else if (hyp_bit)  raw_tgt = LVL2;
    else               raw_tgt = LVL1;
    clamped = raw_tgt < cur_el;
    tgt     = lvl_raise(raw_tgt, cur_el);
  end

endmodule

// File: rtl/hhc_irq_router.sv
module hhc_irq_router
  import hhc_pkg::*;
#(
  parameter int NUM_CLASSES = 3
) (
  input  logic [EL_W-1:0]                  cur_el,
  input  logic                             host_ctx,
  input  logic [NUM_CLASSES-1:0]           route_hyp,
  input  logic [NUM_CLASSES-1:0]           route_mon,
  output logic [NUM_CLASSES-1:0][EL_W-1:0] tgt,
  output logic                             el0_trap,
  output logic [NUM_CLASSES-1:0]           mon_hit,
  output logic [NUM_CLASSES-1:0]           forced,
  output logic [NUM_CLASSES-1:0]           clamped
);

  assign el0_trap = (cur_el == LVL0) && host_ctx;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_lane
    hhc_route_lane u_lane (
      .cur_el   (cur_el),
      .el0_trap (el0_trap),
      .hyp_bit  (route_hyp[c]),
      .mon_bit  (route_mon[c]),
      .tgt      (tgt[c]),
      .mon_hit  (mon_hit[c]),
      .forced   (forced[c]),
      .clamped  (clamped[c])
    );
  end

endmodule

// File: rtl/hhc_bank_sel.sv
module hhc_bank_sel
  import hhc_pkg::*;
(
  input  logic [EL_W-1:0] cur_el,
  input  logic            host_mode,
  input  logic [1:0]      tag_in,
  output logic            bank,
  output logic            undef_acc,
  output logic            redirect_hit,
  output logic            alias_hit
);

  acc_tag_e tag;
  logic     hyp_host;

  assign tag      = acc_tag_e'(tag_in);
  assign hyp_host = (cur_el == LVL2) && host_mode;

  always_comb begin
    bank         = BANK_LOW;
    undef_acc    = 1'b0;
    redirect_hit = 1'b0;
    alias_hit    = 1'b0;
    unique case (tag)
      TAG_LOW_NAME: begin
        redirect_hit = hyp_host;
        bank         = hyp_host ? BANK_HYP : BANK_LOW;
      end
      TAG_HYP_NAME: begin
        bank = BANK_HYP;
      end
      TAG_ALIAS_02: begin
        alias_hit = hyp_host;
        undef_acc = !hyp_host;
        bank      = BANK_LOW;
      end
      default: begin
        undef_acc = 1'b1;
        bank      = BANK_LOW;
      end
    endcase
  end

endmodule

// File: rtl/hhc_regime.sv
module hhc_regime
  import hhc_pkg::*;
(
  input  logic [EL_W-1:0] cur_el,
  input  logic            host_mode,
  input  logic            host_ctx,
  output logic [1:0]      regime,
  output logic            two_regions,
  output logic            asid_en,
  output logic            el0_in_host
);

  regime_e sel;
  regime_t attrs;

  assign el0_in_host = (cur_el == LVL0) && host_mode && host_ctx;

  always_comb begin
    unique case (cur_el)
      LVL0:    sel = el0_in_host ? RGM_HYP : RGM_K10;
      LVL1:    sel = RGM_K10;
      LVL2:    sel = RGM_HYP;
      default: sel = RGM_MON;
    endcase
    attrs = regime_attrs(sel, host_mode);
  end

  assign regime      = attrs.id;
  assign two_regions = attrs.two_regions;
  assign asid_en     = attrs.asid;

endmodule

// File: rtl/hyp_host_ctrl_dec.sv
module hyp_host_ctrl_dec
  import hhc_pkg::*;
#(
  parameter int NUM_CLASSES = 3
) (
  input  logic [1:0]                  cur_el,
  input  logic                        host_mode,
  input  logic                        host_ctx,
  input  logic [NUM_CLASSES-1:0]      route_hyp,
  input  logic [NUM_CLASSES-1:0]      route_mon,
  input  logic [1:0]                  acc_tag,
  output logic [NUM_CLASSES-1:0][1:0] irq_target,
  output logic                        acc_bank,
  output logic                        acc_undef,
  output logic [1:0]                  xlat_regime,
  output logic                        xlat_two_regions,
  output logic                        xlat_asid
);

  // Internal events, named for the bound checker
  logic                   el0_trap;
  logic [NUM_CLASSES-1:0] lane_mon_hit;
  logic [NUM_CLASSES-1:0] lane_forced;
  logic [NUM_CLASSES-1:0] lane_clamped;
  logic                   redirect_hit;
  logic                   alias_hit;
  logic                   el0_in_host;

  hhc_irq_router #(.NUM_CLASSES(NUM_CLASSES)) u_router (
    .cur_el    (cur_el),
    .host_ctx  (host_ctx),
    .route_hyp (route_hyp),
    .route_mon (route_mon),
    .tgt       (irq_target),
    .el0_trap  (el0_trap),
    .mon_hit   (lane_mon_hit),
    .forced    (lane_forced),
    .clamped   (lane_clamped)
  );

  hhc_bank_sel u_bank (
    .cur_el       (cur_el),
    .host_mode    (host_mode),
    .tag_in       (acc_tag),
    .bank         (acc_bank),
    .undef_acc    (acc_undef),
    .redirect_hit (redirect_hit),
    .alias_hit    (alias_hit)
  );

  hhc_regime u_regime (
    .cur_el      (cur_el),
    .host_mode   (host_mode),
    .host_ctx    (host_ctx),
    .regime      (xlat_regime),
    .two_regions (xlat_two_regions),
    .asid_en     (xlat_asid),
    .el0_in_host (el0_in_host)
  );

endmodule

// File: rtl/hyp_host_ctrl_chk.sv
module hyp_host_ctrl_chk #(
  parameter int NUM_CLASSES = 3
) (
  input logic [1:0]                  cur_el,
  input logic                        host_mode,
  input logic                        host_ctx,
  input logic [NUM_CLASSES-1:0]      route_hyp,
  input logic [NUM_CLASSES-1:0]      route_mon,
  input logic [1:0]                  acc_tag,
  input logic [NUM_CLASSES-1:0][1:0] irq_target,
  input logic                        acc_bank,
  input logic                        acc_undef,
  input logic [1:0]                  xlat_regime,
  input logic                        xlat_two_regions,
  input logic                        xlat_asid,
  input logic                        el0_trap,
  input logic [NUM_CLASSES-1:0]      lane_mon_hit,
  input logic [NUM_CLASSES-1:0]      lane_forced,
  input logic [NUM_CLASSES-1:0]      lane_clamped,
  input logic                        redirect_hit,
  input logic                        alias_hit,
  input logic                        el0_in_host
);

  logic known;
  assign known = !$isunknown({cur_el, host_mode, host_ctx, route_hyp, route_mon, acc_tag});

  always_comb begin
    if (known) begin
      for (int c = 0; c < NUM_CLASSES; c++) begin
        // R1
        mon_route_chk: assert (!lane_mon_hit[c] || irq_target[c] == 2'd3)
          else $error("monitor routing lost on class %0d", c);
        // R2
        el0_force_chk: assert (!(lane_forced[c] && el0_trap) || irq_target[c] == 2'd2)
          else $error("level-0 host trap not taken on class %0d", c);
        // R3
        class_route_chk: assert (route_mon[c] || (cur_el == 2'd0 && host_ctx) || cur_el > 2'd1
                                 || irq_target[c] == (route_hyp[c] ? 2'd2 : 2'd1))
          else $error("per-class routing wrong on class %0d", c);
        // R4
        no_lower_chk: assert (irq_target[c] >= cur_el)
          else $error("target below current level on class %0d", c);
        // R4
        clamp_lvl_chk: assert (!lane_clamped[c] || irq_target[c] == cur_el)
          else $error("clamped target not current level on class %0d", c);
      end
      // R5
      redirect_chk: assert (acc_tag != 2'd0
                            || (acc_bank == (cur_el == 2'd2 && host_mode) && !acc_undef
                                && redirect_hit == acc_bank))
        else $error("low-name access bank wrong");
      // R6
      alias_ok_chk: assert (!alias_hit || (acc_bank == 1'b0 && !acc_undef && acc_tag == 2'd2))
        else $error("alias access did not reach low bank");
      // R7
      undef_chk: assert (!acc_undef
                         || (acc_bank == 1'b0
                             && (acc_tag == 2'd3 || (acc_tag == 2'd2 && !(cur_el == 2'd2 && host_mode)))))
        else $error("undefined access flagged wrongly");
      // R8
      hyp_name_chk: assert (acc_tag != 2'd1 || (acc_bank && !acc_undef))
        else $error("hyp-name access bank wrong");
      // R9
      regime_lvl_chk: assert (cur_el == 2'd0 || xlat_regime == cur_el)
        else $error("regime does not follow current level");
      // R9
      el0_space_chk: assert (cur_el != 2'd0 || xlat_regime == (el0_in_host ? 2'd2 : 2'd1))
        else $error("level-0 regime wrong");
      // R10
      asid_pair_chk: assert (xlat_two_regions == xlat_asid)
        else $error("region split and ASID support disagree");
      // R10
      hyp_split_chk: assert (xlat_regime != 2'd2 || xlat_two_regions == host_mode)
        else $error("level-2 regime split wrong");
    end
  end

endmodule

bind hyp_host_ctrl_dec hyp_host_ctrl_chk #(.NUM_CLASSES(NUM_CLASSES)) u_chk (
  .cur_el           (cur_el),
  .host_mode        (host_mode),
  .host_ctx         (host_ctx),
  .route_hyp        (route_hyp),
  .route_mon        (route_mon),
  .acc_tag          (acc_tag),
  .irq_target       (irq_target),
  .acc_bank         (acc_bank),
  .acc_undef        (acc_undef),
  .xlat_regime      (xlat_regime),
  .xlat_two_regions (xlat_two_regions),
  .xlat_asid        (xlat_asid),
  .el0_trap         (el0_trap),
  .lane_mon_hit     (lane_mon_hit),
  .lane_forced      (lane_forced),
  .lane_clamped     (lane_clamped),
  .redirect_hit     (redirect_hit),
  .alias_hit        (alias_hit),
  .el0_in_host      (el0_in_host)
);

// File: tb/test_hyp_host_ctrl_dec.sv
module test_hyp_host_ctrl_dec;

  localparam int NC = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;

  logic [1:0]         cur_el    = '0;
  logic               host_mode = 1'b0;
  logic               host_ctx  = 1'b0;
  logic [NC-1:0]      route_hyp = '0;
  logic [NC-1:0]      route_mon = '0;
  logic [1:0]         acc_tag   = '0;
  logic [NC-1:0][1:0] irq_target;
  logic               acc_bank, acc_undef;
  logic [1:0]         xlat_regime;
  logic               xlat_two_regions, xlat_asid;

  hyp_host_ctrl_dec #(.NUM_CLASSES(NC)) i_hyp_host_ctrl_dec (
    .cur_el, .host_mode, .host_ctx, .route_hyp, .route_mon, .acc_tag,
    .irq_target, .acc_bank, .acc_undef, .xlat_regime, .xlat_two_regions, .xlat_asid
  );

  typedef struct {
    logic [1:0]    el;
    logic          hm;
    logic          hc;
    logic [NC-1:0] hyp;
    logic [NC-1:0] mon;
    logic [1:0]    tag;
  } vec_t;

  vec_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  // Routing model: rules applied in priority order, then the floor
  function automatic logic [1:0] exp_route(input vec_t v, input int c);
    logic [1:0] t;
    if (v.mon[c]) return 2'd3;                        // R1
    t = (v.el == 2'd0 && v.hc) ? 2'd2                 // R2
      : (v.hyp[c] ? 2'd2 : 2'd1);                     // R3
    return (t < v.el) ? v.el : t;                      // R4
  endfunction

  function automatic string req_route(input vec_t v, input int c);
    if (v.mon[c]) return "R1";
    if (v.el > 2'd1) return "R4";
    if (v.el == 2'd0 && v.hc) return "R2";
    return "R3";
  endfunction

  // Returns {undef, bank}
  function automatic logic [1:0] exp_acc(input vec_t v);
    logic at_host = (v.el == 2'd2) && v.hm;
    case (v.tag)
      2'd0:    return {1'b0, at_host};                // R5
      2'd1:    return 2'b01;                          // R8
      2'd2:    return at_host ? 2'b00 : 2'b10;        // R6, R7
      default: return 2'b10;                          // R7
    endcase
  endfunction

  function automatic string req_acc(input vec_t v);
    case (v.tag)
      2'd0:    return "R5";
      2'd1:    return "R8";
      2'd2:    return ((v.el == 2'd2) && v.hm) ? "R6" : "R7";
      default: return "R7";
    endcase
  endfunction

  // Returns {regime[1:0], two_regions, asid}
  function automatic logic [3:0] exp_xlat(input vec_t v);
    logic [1:0] id;
    logic       split;
    if (v.el == 2'd0) id = (v.hm && v.hc) ? 2'd2 : 2'd1;
    else              id = v.el;
    split = (id == 2'd1) || (id == 2'd2 && v.hm);
    return {id, split, split};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(posedge clk);
    #1;
    cur_el    = v.el;
    host_mode = v.hm;
    host_ctx  = v.hc;
    route_hyp = v.hyp;
    route_mon = v.mon;
    acc_tag   = v.tag;
    q.push_back(v);
  endtask

  // Monitor: compare at the falling edge, one item per cycle
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      vec_t       v;
      logic [3:0] xe;
      logic [1:0] ae;
      v = q.pop_front();
      for (int c = 0; c < NC; c++)
        check(req_route(v, c), $sformatf("irq_target[%0d]", c),
              {2'b00, irq_target[c]}, {2'b00, exp_route(v, c)});
      ae = exp_acc(v);
      check(req_acc(v), "acc_undef", {3'b000, acc_undef}, {3'b000, ae[1]});
      check(req_acc(v), "acc_bank",  {3'b000, acc_bank},  {3'b000, ae[0]});
      xe = exp_xlat(v);
      check("R9",  "xlat_regime", {2'b00, xlat_regime}, {2'b00, xe[3:2]});
      check("R10", "xlat_split",  {2'b00, xlat_two_regions, xlat_asid}, {2'b00, xe[1:0]});
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset-state vector: everything low
    v = '{el: 2'd0, hm: 1'b0, hc: 1'b0, hyp: '0, mon: '0, tag: 2'd0};
    drive(v);
    // Exhaustive sweep covers R1 to R10
    for (int e = 0; e < 4; e++)
      for (int m = 0; m < 2; m++)
        for (int h = 0; h < 2; h++)
          for (int y = 0; y < (1 << NC); y++)
            for (int s = 0; s < (1 << NC); s++)
              for (int t = 0; t < 4; t++) begin
                v.el  = 2'(e);
                v.hm  = 1'(m);
                v.hc  = 1'(h);
                v.hyp = NC'(y);
                v.mon = NC'(s);
                v.tag = 2'(t);
                drive(v);
              end
    // R2 with host_mode off: routing trap still applies at level 0
    v = '{el: 2'd0, hm: 1'b0, hc: 1'b1, hyp: '0, mon: 3'b010, tag: 2'd2};
    drive(v);
    // R4 at level 3 with no monitor routing
    v = '{el: 2'd3, hm: 1'b1, hc: 1'b1, hyp: '1, mon: '0, tag: 2'd0};
    drive(v);
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule